// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer with Strong-Pullup Interlock

This block is the timing engine of a single-wire bus master. A free-running 16-bit up-counter paces each time slot. A compare channel pulls the bus low at the start of every slot, and a capture channel records where in the slot the bus last went back high. Software loads the low-pulse width into a preload register and then issues a start. The width for the next bit can be written during the current slot. It only reaches the active compare register at the slot boundary, so one slot never runs with a half-updated width.

Two slot shapes use the same hardware. A bit slot serves both writes and reads: a short pulse writes a one or opens a read, and a long pulse writes a zero. A reset slot holds the bus low for the reset time and then watches for the presence pulse of a device. The period register sets the slot length. For bit slots it covers the slot plus the gap between bits. For reset slots it covers the reset pulse, the wait before presence and the longest presence pulse.

The drive has an interlock. A sense input follows the strong-pullup control. While that input is high, the drive is forced off at once, and the output enable stays cleared. The enable is set again only at a slot boundary where the sense input is low. This prevents a powered bus from being shorted to ground.

Top module: `owslot_timer`

## Requirements
- R1: After reset, and whenever no slot sequence is running, `drive_o`, `busy_o`, `done_o` and `blocked_o` are all 0.
- R2: Once started, the counter runs from 0 up to `period_i` and then returns to 0. Each slot therefore lasts `period_i`+1 cycles, and `period_i` must stay constant while `busy_o` is high.
- R3: `drive_o` is 1 for exactly the first W cycles of a slot, at slot positions 0 to W-1, where W is the active compare width. W = 0 gives no drive at all.
- R4: A write on `width_wr_i` only updates the preload register. The active width takes the preload value on the start command and at every slot boundary. A write during slot k therefore shapes slot k+1, and a write made before the start shapes the first slot.
- R5: In bit mode (`mode_i` = 0), exactly `nslots_i` slots run, and then `busy_o` falls in the cycle after the last slot ends. A count of 0 runs one slot.
- R6: In reset mode (`mode_i` = 1), exactly one slot runs, whatever the value of `nslots_i`.
- R7: If `spu_i` is high when the start is taken, no drive occurs in any slot that begins while `spu_i` stays high, and `blocked_o` is 1 while busy.
- R8: When `spu_i` rises during a slot, `drive_o` drops in the same cycle and stays 0 for the rest of that slot. The drive comes back at the next slot boundary at which `spu_i` is low.
- R9: `cap_o` reports the slot position of the last rising edge of `bus_i` seen at positions below `period_i` in the slot just ended. If there was no such edge, it reports `period_i`.
- R10: `done_o` is a one-cycle pulse in the cycle after each slot's final cycle, and `cap_o` is valid in that same cycle.
- R11: A start command that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 16 | Last counter value of a slot |
| width_wr_i | input | 1 | Write strobe for the preload width |
| width_i | input | 16 | Low-pulse width to preload |
| start_i | input | 1 | Start a slot sequence |
| mode_i | input | 1 | 0 = bit slots, 1 = reset/presence slot |
| nslots_i | input | 8 | Number of bit slots to run |
| spu_i | input | 1 | Strong-pullup active (break) |
| bus_i | input | 1 | Sampled bus level |
| drive_o | output | 1 | Pull-down drive, 1 = bus low |
| busy_o | output | 1 | Slot sequence running |
| blocked_o | output | 1 | Running with output enable cleared |
| done_o | output | 1 | Slot finished pulse |
| cap_o | output | 16 | Captured edge position of last slot |

## Verification
The start command is sampled at a clock edge, and slot position 0 is the cycle that follows that edge. `drive_o` reacts to that position within the same cycle, and it also reacts to `spu_i` in the same cycle because its path is combinational. `done_o` and `cap_o` are registered, so they show up one cycle after position `period_i`, which is also position 0 of the next slot. The bench steps its stimulus through slot positions on falling edges and samples one nanosecond later. It counts drive cycles and slot length from the cycle after the start. It closes each expected item only when `done_o` appears, so every comparison falls in the cycle the requirements name.

// File: rtl/owslot_pkg.sv
package owslot_pkg;
  typedef enum logic {
    SLOT_BIT   = 1'b0,
    SLOT_RESET = 1'b1
  } slot_mode_e;
endpackage

// File: rtl/owslot_counter.sv
module owslot_counter
  import owslot_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  slot_mode_e        mode,
  input  logic [CNT_W-1:0]  period,
  input  logic [SLOT_W-1:0] nslots,
  output logic              run_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] ONE_SLOT = SLOT_W'(1);

  logic              run_q, run_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] left_q, left_d;

  assign wrap_o = run_q && (cnt_q == period);
  assign last_o = (left_q == ONE_SLOT);
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    if (start_go) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      left_d = ((mode == SLOT_RESET) || (nslots == '0)) ? ONE_SLOT : nslots;
    end else if (wrap_o) begin
      cnt_d = '0;
      if (last_o) run_d = 1'b0;
      else        left_d = left_q - ONE_SLOT;
    end else if (run_q) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/owslot_compare.sv
module owslot_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             load,
  input  logic             stop,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic             brk,
  output logic             drive_o,
  output logic             blocked_o
);
  logic [CNT_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             moe_q, moe_d;

  always_comb begin
    pre_d = pre_q;
    act_d = act_q;
    moe_d = moe_q;
    if (wr)   pre_d = wdata;
    if (load) act_d = pre_q;
    if (brk)       moe_d = 1'b0;
    else if (load) moe_d = !stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
      moe_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      act_q <= act_d;
      moe_q <= moe_d;
    end
  end

  assign drive_o   = run && moe_q && !brk && (cnt < act_q);
  assign blocked_o = run && (!moe_q || brk);
endmodule

// File: rtl/owslot_capture.sv
module owslot_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_i,
  input  logic             start_go,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cap_o,
  output logic             done_o
);
  logic             bus_q;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             done_q, done_d;
  logic             rise;

  assign rise = bus_i && !bus_q;

  always_comb begin
    seen_d = seen_q;
    hold_d = hold_q;
    cap_d  = cap_q;
    done_d = 1'b0;
    if (start_go) begin
      seen_d = 1'b0;
    end else if (wrap) begin
      seen_d = 1'b0;
      cap_d  = seen_q ? hold_q : period;
      done_d = 1'b1;
    end else if (run && rise) begin
      hold_d = cnt;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= 1'b1;
      seen_q <= 1'b0;
      hold_q <= '0;
      cap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      bus_q  <= bus_i;
      seen_q <= seen_d;
      hold_q <= hold_d;
      cap_q  <= cap_d;
      done_q <= done_d;
    end
  end

  assign cap_o  = cap_q;
  assign done_o = done_q;
endmodule

// File: rtl/owslot_timer.sv
module owslot_timer
  import owslot_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              width_wr_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [SLOT_W-1:0] nslots_i,
  input  logic              spu_i,
  input  logic              bus_i,
  output logic              drive_o,
  output logic              busy_o,
  output logic              blocked_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cap_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_s;
  logic              run, wrap, last, start_go;
  logic [CNT_W-1:0]  cnt;
  slot_mode_e        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_s = rst_sync_q[SYNC_N-1];

  assign mode     = slot_mode_e'(mode_i);
  assign start_go = start_i && !run;

  owslot_counter #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .start_go(start_go), .mode(mode),
    .period(period_i), .nslots(nslots_i), .run_o(run), .cnt_o(cnt),
    .wrap_o(wrap), .last_o(last)
  );

  owslot_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_s), .wr(width_wr_i), .wdata(width_i),
    .load(start_go || wrap), .stop(wrap && last), .run(run), .cnt(cnt),
    .brk(spu_i), .drive_o(drive_o), .blocked_o(blocked_o)
  );

  owslot_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_s), .bus_i(bus_i), .start_go(start_go),
    .run(run), .wrap(wrap), .cnt(cnt), .period(period_i),
    .cap_o(cap_o), .done_o(done_o)
  );

  assign busy_o = run;
endmodule

// File: rtl/owslot_timer_chk.sv
module owslot_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spu_i,
  input logic             busy_o,
  input logic             drive_o,
  input logic             done_o,
  input logic             wrap,
  input logic             last,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] cap_o
);
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !drive_o);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cnt <= period_i);
  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && last) |=> !busy_o);
  p_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spu_i |-> !drive_o);
  p_cap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cap_o <= $past(period_i));
  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> done_o);
endmodule

bind owslot_timer owslot_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .spu_i(spu_i), .busy_o(busy_o),
  .drive_o(drive_o), .done_o(done_o), .wrap(wrap), .last(last),
  .cnt(cnt), .period_i(period_i), .cap_o(cap_o)
);

// File: tb/tb_owslot_timer.sv
`timescale 1ns/1ps
module tb_owslot_timer;
  localparam int P = 20;

  typedef struct {
    int cap;
    int drv;
    int len;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] period_i, width_i, cap_o;
  logic        width_wr_i, start_i, mode_i, spu_i, bus_i, slave_low;
  logic [7:0]  nslots_i;
  logic        drive_o, busy_o, blocked_o, done_o;

  int    n_chk = 0, n_fail = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;
  assign bus_i = !(drive_o || slave_low);

  owslot_timer dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .width_wr_i(width_wr_i),
    .width_i(width_i), .start_i(start_i), .mode_i(mode_i), .nslots_i(nslots_i),
    .spu_i(spu_i), .bus_i(bus_i), .drive_o(drive_o), .busy_o(busy_o),
    .blocked_o(blocked_o), .done_o(done_o), .cap_o(cap_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int last_rise(input int dend, input int a, input int b);
    int m;
    m = (b > a && b > dend) ? b : dend;
    return (m == 0) ? P : m;
  endfunction

  task automatic push(input int cap, input int drv, input string tag);
    item_t it;
    it.cap = cap; it.drv = drv; it.len = P + 1; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Runs one sequence; stimulus changes on falling edges, one slot position per cycle
  task automatic run_op(input bit mode, input int n, input int nfield,
                        input int w[4], input bit spu0,
                        input int brk_a, input int brk_b,
                        input int sl_a, input int sl_b, input bit start_mid);
    @(negedge clk);
    width_i = 16'(w[0]); width_wr_i = 1'b1;
    @(negedge clk);
    width_wr_i = 1'b0; mode_i = mode; nslots_i = 8'(nfield);
    spu_i = spu0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int s = 0; s < n; s++) begin
      for (int p = 0; p <= P; p++) begin
        slave_low  = (p >= sl_a) && (p < sl_b);
        if (!spu0) spu_i = (s == 0) && (p >= brk_a) && (p < brk_b);
        width_wr_i = (p == 3) && (s + 1 < 4);
        width_i    = (s + 1 < 4) ? 16'(w[s+1]) : 16'd0;
        start_i    = start_mid && (s == 1) && (p == 5);
        if (spu0 && p == 2) begin
          #1 check(blocked_o == 1'b1, "R7 blocked_o", blocked_o, 1);
        end
        @(negedge clk);
      end
    end
    slave_low = 1'b0; spu_i = 1'b0; width_wr_i = 1'b0; start_i = 1'b0;
    #1 check(busy_o == 1'b0, "R5 busy_o after last slot", busy_o, 0);
    @(negedge clk);
    #1 check(exp_q.size() == 0, "R5/R6 slot count", exp_q.size(), 0);
  endtask

  // Monitor: accumulates drive cycles and slot length, compares on done_o
  initial begin
    int drv = 0, len = 0;
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected done_o", 1, 0);
        end else begin
          it = exp_q.pop_front();
          check(int'(cap_o) == it.cap, {it.tag, " R9 cap_o"}, cap_o, it.cap);
          check(drv == it.drv, {it.tag, " R3 drive cycles"}, drv, it.drv);
          check(len == it.len, {it.tag, " R2 slot length"}, len, it.len);
        end
        drv = 0; len = 0;
      end
      if (start_i && !busy_o) begin
        drv = 0; len = 0;
      end else begin
        len++;
        if (drive_o) drv++;
      end
    end
  end

  initial begin
    #4_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; period_i = 16'(P); width_i = '0; width_wr_i = 1'b0;
    start_i = 1'b0; mode_i = 1'b0; nslots_i = '0; spu_i = 1'b0; slave_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(drive_o == 1'b0, "R1 drive_o idle", drive_o, 0);
    check(busy_o == 1'b0, "R1 busy_o idle", busy_o, 0);
    check(done_o == 1'b0, "R1 done_o idle", done_o, 0);
    check(blocked_o == 1'b0, "R1 blocked_o idle", blocked_o, 0);

    // R3 R4 R11: four bit slots, widths reloaded mid-slot, stray start ignored
    push(2, 2, "T1s0"); push(12, 12, "T1s1"); push(2, 2, "T1s2"); push(P, 0, "T1s3");
    run_op(1'b0, 4, 4, '{2, 12, 2, 0}, 1'b0, 0, 0, 0, 0, 1'b1);

    // R9: read slot, device holds bus low to position 9
    push(last_rise(2, 1, 9), 2, "T2");
    run_op(1'b0, 1, 1, '{2, 0, 0, 0}, 1'b0, 0, 0, 1, 9, 1'b0);

    // R6: reset slot with presence 11..16, nslots field ignored
    push(last_rise(8, 11, 16), 8, "T3");
    run_op(1'b1, 1, 3, '{8, 0, 0, 0}, 1'b0, 0, 0, 11, 16, 1'b0);

    // R5: slot count 0 runs one slot
    push(5, 5, "T6");
    run_op(1'b0, 1, 0, '{5, 0, 0, 0}, 1'b0, 0, 0, 0, 0, 1'b0);

    // R7: break high at start blocks both slots
    push(P, 0, "T4s0"); push(P, 0, "T4s1");
    run_op(1'b0, 2, 2, '{5, 5, 0, 0}, 1'b1, 0, 0, 0, 0, 1'b0);

    // R8: break at positions 4..5 of slot 0, re-armed at next boundary
    push(4, 4, "T5s0"); push(10, 10, "T5s1");
    run_op(1'b0, 2, 2, '{10, 10, 0, 0}, 1'b0, 4, 6, 0, 0, 1'b0);

    #1 check(drive_o == 1'b0, "R1 drive_o after runs", drive_o, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule